// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master for Ethernet PHYs. A host writes a small register window. It loads a 16-bit register address and 16-bit write data, then writes a command word. The command word carries the frame type, the opcode, the port address, the device (or register) address and a start flag. The block serialises one complete 64-bit management frame on the MDC/MDIO pins and captures the 16 data bits of a read. If the PHY fails to answer a read, the block records the failure. When the frame is finished, the start flag clears by itself.

Both frame families are supported. A two-bit frame-type field is copied straight onto the wire, so 1 gives the short-address frame and 0 gives the extended-address frame. An extended-address access takes two commands that share the same port and device fields. The first command carries the address register and the second moves the data. MDC is derived from the system clock by a parameterised half-period divider and stays low between frames. MDIO is released whenever no frame is running and during the turnaround and data bits of a read.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, every register in the window reads 0, MDC is low and MDIO is not driven.
- R2: The registers sit at byte offsets 0x00 (command), 0x04 (address), 0x08 (write data), 0x0C (read data) and 0x10 (status). The address and write-data registers read back the low 16 bits written to them. All unused read bits are 0.
- R3: The command word packs its fields as follows: bits 4:0 device/register address, bits 9:5 port address, bits 11:10 opcode, bits 13:12 frame type. Bit 14 is the start/busy flag. Writing the word with bit 14 set while idle launches one frame. Bits 13:0 read back as written.
- R4: Each frame is sent as 64 bits, most significant bit first: 32 ones, then the two frame-type bits, the two opcode bits, the 5-bit port address, the 5-bit device address, two turnaround bits and a 16-bit data field.
- R5: A frame with opcode bit 1 clear is a write-type frame. It drives turnaround 1,0. Its data field comes from the address register when frame type is 0 and opcode is 0. In every other case the data field comes from the write-data register.
- R6: A frame with opcode bit 1 set is a read-type frame. MDIO is released from the first turnaround bit to the end of the frame. The 16 data bits sampled from the PHY, most significant first, appear in the read-data register.
- R7: Status bit 0 is set when the second turnaround bit of a read samples high. It remains set until the next command launches, and a write-type frame never sets it.
- R8: MDC has a period of 2×DIV_HALF clocks while a frame runs and is low otherwise. MDIO changes only together with a falling MDC edge and is sampled on a rising edge. Each frame produces exactly 64 rising edges.
- R9: Command bit 14 reads 1 from the launching clock edge for exactly 128×DIV_HALF clock cycles (64 MDC periods), then 0.
- R10: A command write while busy has no effect: the stored fields, the running frame and the busy period are unchanged, and no further frame follows.
- R11: MDIO output enable is low whenever no frame is in progress.
- R12: A command write with bit 14 clear while idle stores the fields but starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset (write and read) |
| bus_wdata | input | 16 | Write data (only the low half of each word is stored) |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (high drives the pin) |
| mdio_i | input | 1 | MDIO pin value as seen by the block |

## Verification
The hardest situations to reach are a PHY that stays silent during a read and a command written in the middle of a running frame. The bench's behavioural PHY can be switched to absent, so the pulled-up line gives a high second turnaround bit and all-ones data. A second command is also written partway through a frame, with different fields and the start bit set. Every frame is captured bit by bit at the rising MDC edges and compared whole against a 64-bit word assembled from the requirements. The bench sweeps every frame type and opcode combination across several address patterns and checks the busy flag on the exact cycle it should fall.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int REG_AW     = 5;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA1_IDX    = 46;
  localparam int TA2_IDX    = 47;
  localparam int DATA_IDX   = 48;
  localparam int START_BIT  = 14;

  localparam logic [REG_AW-1:0] OFS_CMD   = 5'h00;
  localparam logic [REG_AW-1:0] OFS_ADDR  = 5'h04;
  localparam logic [REG_AW-1:0] OFS_WDATA = 5'h08;
  localparam logic [REG_AW-1:0] OFS_RDATA = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_STAT  = 5'h10;

  // Field order matches command bits 13:0
  typedef struct packed {
    logic [1:0] ftype;
    logic [1:0] opc;
    logic [4:0] port;
    logic [4:0] dev;
  } mdio_cmd_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  logic mdc_q, mdc_d;
  logic wrap;

  generate
    if (DIV_HALF == 1) begin : g_nodiv
      assign wrap = run;
    end else begin : g_div
      localparam int CW = $clog2(DIV_HALF);
      logic [CW-1:0] cnt_q, cnt_d;
      assign wrap = run && (cnt_q == CW'(DIV_HALF - 1));
      always_comb begin
        if (!run)      cnt_d = '0;
        else if (wrap) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

  always_comb begin
    if (!run)      mdc_d = 1'b0;
    else if (wrap) mdc_d = ~mdc_q;
    else           mdc_d = mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdc_q <= 1'b0;
    else        mdc_q <= mdc_d;
  end

  assign mdc       = mdc_q;
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap &&  mdc_q;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              busy,
  input  logic              fail,
  input  logic [15:0]       rd_word,
  output logic [31:0]       bus_rdata,
  output logic              launch,
  output mdio_cmd_t         launch_cmd,
  output logic [15:0]       addr_reg,
  output logic [15:0]       wdata_reg
);
  mdio_cmd_t   cmd_q, cmd_d;
  logic [15:0] addr_q, addr_d, wd_q, wd_d;
  logic        cmd_acc;

  assign cmd_acc    = bus_wr && (bus_addr == OFS_CMD) && !busy;
  assign launch     = cmd_acc && bus_wdata[START_BIT];
  assign launch_cmd = mdio_cmd_t'(bus_wdata[13:0]);

  always_comb begin
    cmd_d  = cmd_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    if (cmd_acc)                            cmd_d  = mdio_cmd_t'(bus_wdata[13:0]);
    if (bus_wr && bus_addr == OFS_ADDR)     addr_d = bus_wdata;
    if (bus_wr && bus_addr == OFS_WDATA)    wd_d   = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      cmd_q  <= cmd_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CMD:   bus_rdata = {17'b0, busy, cmd_q};
      OFS_ADDR:  bus_rdata = {16'b0, addr_q};
      OFS_WDATA: bus_rdata = {16'b0, wd_q};
      OFS_RDATA: bus_rdata = {16'b0, rd_word};
      OFS_STAT:  bus_rdata = {31'b0, fail};
      default:   bus_rdata = '0;
    endcase
  end

  assign addr_reg  = addr_q;
  assign wdata_reg = wd_q;
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  mdio_cmd_t   launch_cmd,
  input  logic [15:0] addr_reg,
  input  logic [15:0] wdata_reg,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        busy,
  output logic        fail,
  output logic [15:0] rd_word,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

  logic                  busy_q, busy_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  rd_q, rd_d;
  logic [15:0]           rdat_q, rdat_d;
  logic                  fail_q, fail_d;
  logic [15:0]           field;
  logic [FRAME_BITS-1:0] word;

  always_comb begin
    if (launch_cmd.ftype == 2'd0 && launch_cmd.opc == 2'd0) field = addr_reg;
    else                                                    field = wdata_reg;
    word = {{PRE_BITS{1'b1}}, launch_cmd.ftype, launch_cmd.opc,
            launch_cmd.port, launch_cmd.dev, 2'b10, field};
  end

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    rd_d   = rd_q;
    rdat_d = rdat_q;
    fail_d = fail_q;
    if (launch) begin
      busy_d = 1'b1;
      idx_d  = '0;
      sh_d   = word;
      rd_d   = launch_cmd.opc[1];
      fail_d = 1'b0;
    end else if (busy_q) begin
      if (rise_tick && rd_q) begin
        if (idx_q == IDX_W'(TA2_IDX) && mdio_i) fail_d = 1'b1;
        if (idx_q >= IDX_W'(DATA_IDX))          rdat_d = {rdat_q[14:0], mdio_i};
      end
      if (fall_tick) begin
        if (idx_q == LAST) begin
          busy_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      rd_q   <= 1'b0;
      rdat_q <= '0;
      fail_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      rd_q   <= rd_d;
      rdat_q <= rdat_d;
      fail_q <= fail_d;
    end
  end

  assign mdio_oe = busy_q && !(rd_q && idx_q >= IDX_W'(TA1_IDX));
  assign mdio_o  = mdio_oe && sh_q[FRAME_BITS-1];
  assign busy    = busy_q;
  assign fail    = fail_q;
  assign rd_word = rdat_q;
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic        rst_m, rst_s;
  logic        busy, fail, launch, rise_tick, fall_tick;
  mdio_cmd_t   launch_cmd;
  logic [15:0] addr_reg, wdata_reg, rd_word;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  mdio_regs u_regs (
    .clk(clk), .rst_n(rst_s), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .fail(fail), .rd_word(rd_word),
    .bus_rdata(bus_rdata), .launch(launch), .launch_cmd(launch_cmd),
    .addr_reg(addr_reg), .wdata_reg(wdata_reg)
  );

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk(clk), .rst_n(rst_s), .run(busy), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame u_frame (
    .clk(clk), .rst_n(rst_s), .launch(launch), .launch_cmd(launch_cmd),
    .addr_reg(addr_reg), .wdata_reg(wdata_reg), .rise_tick(rise_tick),
    .fall_tick(fall_tick), .mdio_i(mdio_i), .busy(busy), .fail(fail),
    .rd_word(rd_word), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk #(
  parameter int DIV_HALF = 10
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic fail,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  logic [31:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  p_hiz_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  p_mdc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  p_hold_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_end_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(mdc));

  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == 32'(128 * DIV_HALF)));

  p_fail_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !fail);
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk(clk), .rst_n(rst_s), .busy(busy), .fail(fail),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb;
  localparam int DH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = 5'h00;
  logic [15:0] bus_wdata = 16'h0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int vectors = 0;
  int fails   = 0;
  int falls   = 0;
  int rises   = 0;
  int base_fall = 0;
  logic [63:0] cap = '0;
  logic        phy_rd = 1'b0;
  logic        phy_present = 1'b1;
  logic [15:0] phy_data = 16'h0;
  logic        phy_out;
  int          rel;

  always #10 clk = ~clk;

  mdio_mgmt_master #(.DIV_HALF(DH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // behavioural PHY with a pull-up on the line
  always_comb begin
    rel = falls - base_fall;
    phy_out = 1'b1;
    if (phy_rd && phy_present && rel >= 47 && rel <= 63)
      phy_out = (rel == 47) ? 1'b0 : phy_data[63 - rel];
  end
  assign mdio_i = mdio_oe ? mdio_o : phy_out;

  always @(negedge mdc) falls <= falls + 1;
  always @(posedge mdc) begin
    cap   <= {cap[62:0], mdio_i};
    rises <= rises + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  function automatic logic [15:0] cmdw(input logic [1:0] st, input logic [1:0] op,
                                       input logic [4:0] prt, input logic [4:0] dev,
                                       input logic go);
    return {1'b0, go, st, op, prt, dev};
  endfunction

  function automatic logic [63:0] expect_frame(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] prt, input logic [4:0] dev, input logic [15:0] av,
      input logic [15:0] wv, input logic present, input logic [15:0] pd);
    logic [1:0]  ta;
    logic [15:0] dv;
    if (op[1]) begin
      ta = present ? 2'b10 : 2'b11;
      dv = present ? pd : 16'hFFFF;
    end else begin
      ta = 2'b10;
      dv = (st == 2'd0 && op == 2'd0) ? av : wv;
    end
    return {32'hFFFF_FFFF, st, op, prt, dev, ta, dv};
  endfunction

  task automatic frame(input logic [1:0] st, input logic [1:0] op, input logic [4:0] prt,
                       input logic [4:0] dev, input logic [15:0] av, input logic [15:0] wv,
                       input logic present, input logic [15:0] pd);
    logic [31:0] v;
    int r0;
    wr(5'h04, av);
    wr(5'h08, wv);
    phy_rd = op[1]; phy_present = present; phy_data = pd;
    base_fall = falls;
    r0 = rises;
    wr(5'h00, cmdw(st, op, prt, dev, 1'b1));
    rd(5'h00, v);
    chk("R3 launch sets busy", {63'b0, v[14]}, 64'd1);
    repeat (128*DH - 1) @(negedge clk);
    rd(5'h00, v);
    chk("R9 busy before end", {63'b0, v[14]}, 64'd1);
    @(negedge clk);
    rd(5'h00, v);
    chk("R9 busy cleared", {63'b0, v[14]}, 64'd0);
    chk("R3 fields readback", {50'b0, v[13:0]}, {50'b0, cmdw(st, op, prt, dev, 1'b0)});
    chk("R4 R5 R6 frame bits", cap, expect_frame(st, op, prt, dev, av, wv, present, pd));
    chk("R8 rising edges", 64'(rises - r0), 64'd64);
    chk("R11 released after frame", {63'b0, mdio_oe}, 64'd0);
    rd(5'h10, v);
    chk("R7 status", 64'(v), {63'b0, op[1] & ~present});
    if (op[1]) begin
      rd(5'h0C, v);
      chk("R6 read data", 64'(v), {48'b0, present ? pd : 16'hFFFF});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int r0;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a <= 16; a += 4) begin
      rd(5'(a), v);
      chk("R1 reset register", 64'(v), 64'd0);
    end
    chk("R1 mdc low", {63'b0, mdc}, 64'd0);
    chk("R1 R11 not driven", {63'b0, mdio_oe}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: register map and width
    wr(5'h04, 16'hBEEF);
    wr(5'h08, 16'h1357);
    rd(5'h04, v); chk("R2 address reg", 64'(v), 64'h0000BEEF);
    rd(5'h08, v); chk("R2 wdata reg", 64'(v), 64'h00001357);
    rd(5'h14, v); chk("R2 unmapped", 64'(v), 64'd0);

    // R12: store without start
    r0 = rises;
    wr(5'h00, cmdw(2'd1, 2'd2, 5'h0A, 5'h15, 1'b0));
    repeat (20) @(negedge clk);
    rd(5'h00, v);
    chk("R12 fields stored, no busy", 64'(v), {48'b0, cmdw(2'd1, 2'd2, 5'h0A, 5'h15, 1'b0)});
    chk("R12 no frame", 64'(rises - r0), 64'd0);

    // sweep: both frame types, all opcodes, several address patterns
    for (int st = 0; st < 2; st++)
      for (int op = 0; op < 4; op++)
        for (int k = 0; k < 3; k++)
          frame(2'(st), 2'(op), 5'(k*11 + op*3 + 1), 5'(31 - k*7 - st),
                16'(16'hA5C3 ^ (k * 16'h1111)), 16'(16'h3C5A + k*16'h0F0F + op),
                1'b1, 16'(16'h8001 ^ (k*16'h2468) ^ (op << 4)));

    // R7: absent PHY on a read, sticky, then cleared on next launch
    frame(2'd1, 2'd2, 5'h05, 5'h02, 16'h0, 16'h0, 1'b0, 16'h0);
    frame(2'd0, 2'd3, 5'h1F, 5'h1E, 16'h0, 16'h0, 1'b0, 16'h0);
    repeat (30) @(negedge clk);
    rd(5'h10, v); chk("R7 sticky", 64'(v), 64'd1);
    wr(5'h00, cmdw(2'd1, 2'd1, 5'h01, 5'h01, 1'b1));
    rd(5'h10, v); chk("R7 cleared at launch", 64'(v), 64'd0);
    repeat (128*DH + 4) @(negedge clk);
    rd(5'h10, v); chk("R7 write frame leaves status clear", 64'(v), 64'd0);

    // R10: command write during a frame is ignored
    wr(5'h08, 16'hC0DE);
    phy_rd = 1'b0;
    base_fall = falls;
    r0 = rises;
    wr(5'h00, cmdw(2'd1, 2'd1, 5'h03, 5'h09, 1'b1));
    repeat (40) @(negedge clk);
    wr(5'h00, cmdw(2'd0, 2'd3, 5'h1C, 5'h11, 1'b1));
    repeat (128*DH - 42) @(negedge clk);
    rd(5'h00, v);
    chk("R10 busy period unchanged", {63'b0, v[14]}, 64'd0);
    chk("R10 fields unchanged", {50'b0, v[13:0]}, {50'b0, cmdw(2'd1, 2'd1, 5'h03, 5'h09, 1'b0)});
    chk("R10 frame unchanged", cap, expect_frame(2'd1, 2'd1, 5'h03, 5'h09, 16'h0, 16'hC0DE, 1'b1, 16'h0));
    repeat (300) @(negedge clk);
    chk("R10 no second frame", 64'(rises - r0), 64'd64);
    chk("R11 idle not driven", {63'b0, mdio_oe}, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule